// File: doc/BRIEF.md
# Destination Address Multicast Hash Filter

This block sits behind a receive MAC and decides whether an incoming frame should be kept, judging only by its 48-bit destination address. The six destination bytes arrive one per cycle on a valid/byte stream, with a marker on the first byte. While they arrive, the block folds each byte into a CRC-32 and compares it against the station's own address. The top six bits of the finished CRC pick one bit out of a 64-bit multicast hash table. One cycle after the sixth byte, the block raises a one-cycle decision strobe together with the accept verdict.

Software programs the hash table, the station address and four mode bits through a simple write port. The mode bits enable own-address acceptance, broadcast acceptance, all-multicast and promiscuous operation. Bytes that follow the address are ignored until the next first-byte marker. A first-byte marker arriving in the middle of an address restarts collection.

Every state and transition of the control FSM is named here. IDLE waits for a first byte (first → ADDR). ADDR gathers the remaining bytes (fifth further byte → REPORT; first byte → ADDR, restart). REPORT is the single decision cycle (first byte → ADDR, otherwise → SKIP). SKIP discards trailing bytes (first byte → ADDR).

Top module: `mcast_addr_filter`

## Requirements
- R1: After reset, decision_valid and accept are 0 and the hash table, station address and mode bits are all 0, so a multicast destination is rejected.
- R2: decision_valid is 1 for exactly the one cycle that follows the clock edge that captures the sixth address byte, and 0 in every other cycle; accept is 0 whenever decision_valid is 0.
- R3: The hash index is bits 31:26 of a CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF, with no final inversion. The CRC runs over the six bytes in arrival order, each byte least significant bit first, and shifts the register toward bit 31. An index below 32 selects that bit of the low hash word (cfg_sel=0); an index of 32 or more selects bit index−32 of the high hash word (cfg_sel=1).
- R4: A destination whose first byte has bit 0 set, and which is not all ones, is accepted only when its hash bit is 1 and multicast acceptance is enabled. Multicast acceptance is enabled when any hash bit is 1 or all-multicast mode is on.
- R5: The all-ones destination is broadcast. It is never looked up in the hash table and is accepted exactly when the broadcast-enable mode bit (cfg_sel=4, bit 1) is 1, or promiscuous mode is on.
- R6: A destination with first-byte bit 0 clear is accepted when it equals the station address and the own-address enable bit (cfg_sel=4, bit 0) is 1. The first received byte is compared with station bits 47:40, and so on down. The station low word is cfg_sel=2 and the high 16 bits are cfg_sel=3, taken from wdata[15:0].
- R7: With the promiscuous bit (cfg_sel=4, bit 3) set, every destination is accepted.
- R8: Writing a mode value with the all-multicast bit (cfg_sel=4, bit 2) or the promiscuous bit set fills both hash words with ones. While either bit is on, writes to the hash words are ignored. The ones remain after the mode is cleared, until the hash words are rewritten.
- R9: Bytes after the sixth produce no further decision until a first-byte marker arrives. A first-byte marker partway through an address discards the partial address and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 hash low, 1 hash high, 2 station low, 3 station high, 4 mode |
| cfg_wdata | input | 32 | Configuration write data |
| rx_valid | input | 1 | Address byte valid |
| rx_first | input | 1 | Marks the first destination byte of a frame |
| rx_byte | input | 8 | Destination byte |
| decision_valid | output | 1 | One-cycle strobe qualifying accept |
| accept | output | 1 | Keep the frame |

## Verification
The central sweep programs the hash table with one bit at a time across all 64 positions. For each position it sends a fixed set of multicast destinations, so each address is accepted for exactly one position. This separates a wrong CRC bit order, a wrong index slice and a swapped low/high word. Broadcast, the own address and a near-miss unicast are each tried with their enable bit on and off, to tell the broadcast, own-address and multicast paths apart. Mode sequences check the fill-with-ones rule and the stickiness of the hash words, and an over-long and a restarted address check that the FSM produces one decision per marker.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_REPORT,
        ST_SKIP
    } mcf_state_e;

    typedef struct packed {
        logic promisc;
        logic allmulti;
        logic bcast_en;
        logic own_en;
    } mcf_mode_t;

    // One byte of the MSB-first CRC, data bits consumed LSB first
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[31] ^ b[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction
endpackage

// File: rtl/mcf_cfg_regs.sv
module mcf_cfg_regs
    import mcf_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int WORD_W = 32,
    parameter int STA_W  = 48
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [SEL_W-1:0]      sel,
    input  logic [WORD_W-1:0]     wdata,
    output logic [2*WORD_W-1:0]   hash,
    output logic [STA_W-1:0]      station,
    output mcf_mode_t             mode
);
    localparam int HI_W = STA_W - WORD_W;
    localparam logic [SEL_W-1:0] SEL_HLO  = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_HHI  = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_SLO  = SEL_W'(2);
    localparam logic [SEL_W-1:0] SEL_SHI  = SEL_W'(3);
    localparam logic [SEL_W-1:0] SEL_MODE = SEL_W'(4);

    mcf_mode_t new_mode;
    logic      flood_now;

    assign new_mode  = mcf_mode_t'(wdata[3:0]);
    assign flood_now = mode.allmulti | mode.promisc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hash    <= '0;
            station <= '0;
            mode    <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_HLO:  if (!flood_now) hash[WORD_W-1:0] <= wdata;
                SEL_HHI:  if (!flood_now) hash[2*WORD_W-1:WORD_W] <= wdata;
                SEL_SLO:  station[WORD_W-1:0] <= wdata;
                SEL_SHI:  station[STA_W-1:WORD_W] <= wdata[HI_W-1:0];
                SEL_MODE: begin
                    mode <= new_mode;
                    if (new_mode.allmulti | new_mode.promisc) hash <= '1;
                end
                default: ;
            endcase
        end
    end

    // R8: the flooding modes always leave a full hash table
    a_r8_flood_full: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.allmulti | mode.promisc) |-> (&hash));
    // R8: hash words are frozen while flooding
    a_r8_hash_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (flood_now && !(we && sel == SEL_MODE)) |=> $stable(hash));
endmodule

// File: rtl/mcf_hash_lookup.sv
module mcf_hash_lookup #(
    parameter int IDX_W = 6
) (
    input  logic [(1<<IDX_W)-1:0] hash,
    input  logic [IDX_W-1:0]      idx,
    output logic                  hit,
    output logic                  any_set
);
    localparam int BANK_W = 1 << (IDX_W - 1);

    logic [1:0] bank_bit;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_bank
            assign bank_bit[g] = hash[g*BANK_W + int'(idx[IDX_W-2:0])];
        end
    endgenerate

    assign hit     = idx[IDX_W-1] ? bank_bit[1] : bank_bit[0];
    assign any_set = |hash;
endmodule

// File: rtl/mcast_addr_filter.sv
module mcast_addr_filter
    import mcf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 6,
    parameter int SEL_W      = 3,
    parameter int WORD_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic [7:0]        rx_byte,
    output logic              decision_valid,
    output logic              accept
);
    localparam int STA_W  = 8 * ADDR_BYTES;
    localparam int CNT_W  = $clog2(ADDR_BYTES + 1);
    localparam int HASH_W = 1 << IDX_W;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);

    logic [HASH_W-1:0] hash;
    logic [STA_W-1:0]  station;
    mcf_mode_t         mode;

    mcf_state_e        state, state_nx;
    logic [31:0]       crc;
    logic [CNT_W-1:0]  cnt;
    logic              is_mc, all_ff, own_eq;
    logic              hit, any_set;
    logic              start, take;

    mcf_cfg_regs #(.SEL_W(SEL_W), .WORD_W(WORD_W), .STA_W(STA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .hash(hash), .station(station), .mode(mode)
    );

    mcf_hash_lookup #(.IDX_W(IDX_W)) u_lookup (
        .hash(hash), .idx(crc[31 -: IDX_W]), .hit(hit), .any_set(any_set)
    );

    function automatic logic [7:0] sta_byte(input logic [CNT_W-1:0] k);
        logic [7:0] r;
        r = '0;
        for (int i = 0; i < ADDR_BYTES; i++)
            if (k == CNT_W'(i)) r = station[8*(ADDR_BYTES-1-i) +: 8];
        return r;
    endfunction

    assign start = rx_valid && rx_first;
    assign take  = rx_valid && !rx_first && (state == ST_ADDR);

    // Next state
    always_comb begin
        state_nx = state;
        if (start) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_IDLE;
                ST_ADDR:   if (take && cnt == LAST_CNT) state_nx = ST_REPORT;
                ST_REPORT: state_nx = ST_SKIP;
                ST_SKIP:   state_nx = ST_SKIP;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Address collection datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc    <= CRC_SEED;
            cnt    <= '0;
            is_mc  <= 1'b0;
            all_ff <= 1'b0;
            own_eq <= 1'b0;
        end else if (start) begin
            crc    <= crc_step(CRC_SEED, rx_byte);
            cnt    <= CNT_W'(1);
            is_mc  <= rx_byte[0];
            all_ff <= (rx_byte == 8'hFF);
            own_eq <= (rx_byte == sta_byte('0));
        end else if (take) begin
            crc    <= crc_step(crc, rx_byte);
            cnt    <= cnt + CNT_W'(1);
            all_ff <= all_ff && (rx_byte == 8'hFF);
            own_eq <= own_eq && (rx_byte == sta_byte(cnt));
        end
    end

    // Outputs
    always_comb begin
        decision_valid = (state == ST_REPORT);
        accept         = 1'b0;
        if (decision_valid) begin
            if (mode.promisc)  accept = 1'b1;
            else if (all_ff)   accept = mode.bcast_en;
            else if (is_mc)    accept = (any_set || mode.allmulti) && hit;
            else               accept = mode.own_en && own_eq;
        end
    end

    // R2: one-cycle strobe, preceded by a captured byte
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid |=> !decision_valid);
    a_r2_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid |-> $past(rx_valid));
    a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !decision_valid |-> !accept);
    // R7: promiscuous keeps everything
    a_r7_promisc: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && mode.promisc) |-> accept);
    // R5: broadcast refused when its enable is off
    a_r5_bcast_off: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && all_ff && !mode.bcast_en && !mode.promisc) |-> !accept);
    // R4: empty table without all-multicast refuses multicast
    a_r4_empty_table: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && is_mc && !all_ff && hash == '0 && !mode.allmulti
         && !mode.promisc) |-> !accept);
endmodule

// File: tb/mcast_addr_filter_tb.sv
`timescale 1ns/1ps
module mcast_addr_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rx_valid = 1'b0;
    logic        rx_first = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        decision_valid, accept;

    int checks = 0;
    int fails  = 0;

    // bench-side model state
    logic [63:0] m_hash = '0;
    logic [47:0] m_sta  = '0;
    logic [3:0]  m_mode = '0;

    always #2.5 clk = ~clk;

    mcast_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_first(rx_first),
        .rx_byte(rx_byte), .decision_valid(decision_valid), .accept(accept)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [5:0] idx_of(input logic [47:0] a);
        logic [31:0] c;
        logic [7:0]  b;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            b = a[47-8*k -: 8];
            for (int i = 0; i < 8; i++) begin
                fb = c[31] ^ b[i];
                c  = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c[31:26];
    endfunction

    function automatic logic model(input logic [47:0] a);
        if (m_mode[3]) return 1'b1;
        if (a == 48'hFFFF_FFFF_FFFF) return m_mode[1];
        if (a[40]) return ((|m_hash) || m_mode[2]) && m_hash[idx_of(a)];
        return m_mode[0] && (a == m_sta);
    endfunction

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        unique case (sel)
            3'd0: if (!(m_mode[2] | m_mode[3])) m_hash[31:0] = d;
            3'd1: if (!(m_mode[2] | m_mode[3])) m_hash[63:32] = d;
            3'd2: m_sta[31:0] = d;
            3'd3: m_sta[47:32] = d[15:0];
            3'd4: begin m_mode = d[3:0]; if (d[3] | d[2]) m_hash = '1; end
            default: ;
        endcase
    endtask

    task automatic push(input logic [7:0] b, input logic first);
        @(negedge clk);
        rx_valid = 1'b1; rx_first = first; rx_byte = b;
    endtask

    // sends an address, then samples the decision cycle
    task automatic send(input logic [47:0] a, output logic v, output logic acc);
        for (int k = 0; k < 6; k++) push(a[47-8*k -: 8], k == 0);
        @(negedge clk);
        rx_valid = 1'b0; rx_first = 1'b0;
        v = decision_valid; acc = accept;
        @(negedge clk);
    endtask

    task automatic try_addr(input string req, input logic [47:0] a);
        logic v, acc;
        send(a, v, acc);
        check(req, v, 1'b1);
        check(req, acc, model(a));
    endtask

    function automatic logic [47:0] mc_addr(input int j);
        return {8'(8'h01 + 2*j), 8'h00, 8'h5E, 8'(j*37), 8'(j*11 + 3), 8'(j)};
    endfunction

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: got hung expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic v, acc;
        logic [47:0] own;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 valid", decision_valid, 1'b0);
        check("R1 accept", accept, 1'b0);
        send(mc_addr(0), v, acc);
        check("R1 mcast rejected", acc, 1'b0);

        // R6 / R5 own and broadcast paths
        own = 48'h02_11_22_33_44_55;
        wr(3'd2, own[31:0]);
        wr(3'd3, {16'h0, own[47:32]});
        wr(3'd4, 32'h3);
        try_addr("R6 own", own);
        try_addr("R6 near miss", own ^ 48'h1);
        try_addr("R6 first byte differs", own ^ 48'h04_0000_0000_00);
        try_addr("R5 bcast on", 48'hFFFF_FFFF_FFFF);
        wr(3'd4, 32'h1);
        try_addr("R5 bcast off", 48'hFFFF_FFFF_FFFF);
        wr(3'd4, 32'h2);
        try_addr("R6 own off", own);

        // R2 timing: no strobe before the decision cycle nor after it
        for (int k = 0; k < 6; k++) begin
            push(own[47-8*k -: 8], k == 0);
            if (k > 0) check("R2 early", decision_valid, 1'b0);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        check("R2 strobe", decision_valid, 1'b1);
        @(negedge clk);
        check("R2 width", decision_valid, 1'b0);
        check("R2 accept low", accept, 1'b0);

        // R3 / R4 single-bit sweep over the whole table
        wr(3'd4, 32'h0);
        for (int b = 0; b < 64; b++) begin
            logic [63:0] h;
            h = 64'h1 << b;
            wr(3'd0, h[31:0]);
            wr(3'd1, h[63:32]);
            for (int j = 0; j < 8; j++) try_addr("R3 R4 hash sweep", mc_addr(j));
        end

        // R4 enable: empty table rejects, all-multicast accepts
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        try_addr("R4 empty table", mc_addr(3));
        // R8 flooding fills and freezes the table
        wr(3'd4, 32'h4);
        wr(3'd0, 32'h0);
        for (int j = 0; j < 4; j++) try_addr("R8 allmulti", mc_addr(j));
        wr(3'd4, 32'h0);
        for (int j = 4; j < 8; j++) try_addr("R8 sticky ones", mc_addr(j));
        check("R8 model sticky", m_hash[idx_of(mc_addr(5))], 1'b1);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        try_addr("R8 rewrite clears", mc_addr(6));

        // R7 promiscuous
        wr(3'd4, 32'h8);
        try_addr("R7 foreign unicast", 48'h0A_0B_0C_0D_0E_0F);
        try_addr("R7 bcast", 48'hFFFF_FFFF_FFFF);
        try_addr("R7 mcast", mc_addr(2));

        // R9 trailing bytes and restart
        wr(3'd4, 32'h1);
        send(own, v, acc);
        check("R9 first decision", acc, 1'b1);
        for (int k = 0; k < 8; k++) begin
            push(8'(k), 1'b0);
            @(negedge clk);
            rx_valid = 1'b0;
            check("R9 trailing ignored", decision_valid, 1'b0);
        end
        push(8'h99, 1'b1);
        push(8'h98, 1'b0);
        push(8'h97, 1'b0);
        send(own, v, acc);
        check("R9 restart valid", v, 1'b1);
        check("R9 restart accept", acc, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule